// File: doc/BRIEF.md
# Masked Edge Interrupt Collector

The block gathers rising edges from a small set of interrupt sources into one byte-wide register. A write to the register loads an enable mask with one bit per source. A read shows which enabled sources have seen a rising edge since they were last enabled. One interrupt request line stays high while any of these pending bits is set.

There is no separate acknowledge path. Removing a source's enable bit clears that source's pending bit. A handler therefore reads the status and writes back a mask with the newly seen sources removed. It repeats this until the status reads zero, then writes the original mask back at once. The bus decode that produces the write strobe and the logic behind each source input both sit outside this block.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset the enable mask and all pending bits are zero, the read value is 0x00 and `irq` is low.
- R2: A cycle with `wr_en` high loads `wr_data[5:0]` as the new enable mask, bit n enabling source n. The new mask takes effect from the following clock edge.
- R3: A source's pending bit is set when the source input goes from low to high while its enable bit is 1. Edges on disabled sources leave no trace.
- R4: Read bits 7:6 are always 0, even after a write that sets them. Bits 5:0 carry the pending bits, bit n for source n.
- R5: `irq` is high exactly when at least one pending bit is set, in the same cycle as the read value.
- R6: Clearing a source's enable bit clears its pending bit on that write's clock edge. Other pending bits are unaffected.
- R7: If a source edge arrives in the same cycle as a write that clears that source's enable bit, the pending bit stays clear.
- R8: Writing 0x00 clears every pending bit and drops `irq` on the next edge.
- R9: A pending bit stays set while its source remains enabled, whatever the source input does afterwards.
- R10: Only a low-to-high transition sets a pending bit. A source held high across a mask/unmask sequence does not set it again until it falls and rises once more.
- R11: An edge in the same cycle as the write that first enables that source is not captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the enable mask |
| wr_data | input | 8 | Enable mask to load; bit n enables source n |
| src_in | input | 6 | Source input levels, one per source |
| rd_data | output | 8 | Pending status; bits above the source count read 0 |
| irq | output | 1 | High while any pending bit is set |

## Verification
A wrong enable mask inside the block shows up one clock edge after the next source edge. The edge is either captured when it should be dropped, or dropped when it should be captured, and both `rd_data` and `irq` differ from the model in that cycle. A wrong stored previous input level shows up as an extra capture, or a missing one, on the first enabled edge that follows. A pending bit that fails to clear is seen on the edge of the masking write. The reference model checks the outputs on every cycle. Directed sequences cover the races between a write and a source edge, where a fault would otherwise stay hidden.

// File: rtl/irqse_pkg.sv
package irqse_pkg;
    localparam int unsigned REG_BITS = 8;
    typedef logic [REG_BITS-1:0] reg_byte_t;
endpackage

// File: rtl/irqse_edge.sv
module irqse_edge #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = lvl & ~st_q.prev;
endmodule

// File: rtl/irqse_pend.sv
module irqse_pend #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_mask,
    input  logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] pend,
    output logic [WIDTH-1:0] en
);
    typedef struct packed {
        logic [WIDTH-1:0] en;
        logic [WIDTH-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.en = wr_mask;
        for (int i = 0; i < int'(WIDTH); i++) begin
            // capture gated by the old mask, cleared by the new one
            st_d.pend[i] = (st_q.pend[i] | (rise[i] & st_q.en[i])) & st_d.en[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign en   = st_q.en;

    // R6
    mask_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend & ~st_q.en) == '0);

    // R3
    gated_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend & ~$past(st_q.pend) & ~$past(st_q.en)) == '0);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.pend) & st_q.en & ~st_q.pend) == '0);
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
    import irqse_pkg::*;
#(
    parameter int unsigned NUM_SRC = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_BITS-1:0] wr_data,
    input  logic [NUM_SRC-1:0]  src_in,
    output logic [REG_BITS-1:0] rd_data,
    output logic                irq
);
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] en;

    irqse_edge #(.WIDTH(NUM_SRC)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (src_in),
        .rise  (rise)
    );

    irqse_pend #(.WIDTH(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_mask (wr_data[NUM_SRC-1:0]),
        .rise    (rise),
        .pend    (pend),
        .en      (en)
    );

    generate
        if (NUM_SRC < REG_BITS) begin : g_pad
            logic unused_hi_bits;
            assign unused_hi_bits = ^wr_data[REG_BITS-1:NUM_SRC];
            assign rd_data = {{(REG_BITS - NUM_SRC){1'b0}}, pend};
        end else begin : g_full
            assign rd_data = pend;
        end
    endgenerate

    assign irq = |pend;

    // R10
    needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~$past(src_in)) == '0);

    // R10
    needs_low_before_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & $past(src_in, 2)) == '0);

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(src_in & en) != '0));
endmodule

// File: tb/irq_src_ctrl_bench.sv
module irq_src_ctrl_bench;
    logic       clk;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [5:0] src_in;
    logic [7:0] rd_data;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [5:0] m_en, m_pend, m_prev;

    irq_src_ctrl u_irq_src_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .src_in  (src_in),
        .rd_data (rd_data),
        .irq     (irq)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en   = '0;
            m_pend = '0;
            m_prev = '0;
        end else begin
            logic [5:0] edges, newen;
            edges = src_in & ~m_prev;
            newen = wr_en ? wr_data[5:0] : m_en;
            m_pend = (m_pend | (edges & m_en)) & newen;
            m_en   = newen;
            m_prev = src_in;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (rd_data !== {2'b00, m_pend}) begin
            n_bad++;
            $display("FAIL R3 cycle status got %h expected %h", rd_data, {2'b00, m_pend});
        end
        n_cmp++;
        if (irq !== (m_pend != 0)) begin
            n_bad++;
            $display("FAIL R5 cycle irq got %b expected %b", irq, (m_pend != 0));
        end
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired got 0 expected 1");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; src_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R1 reset status", rd_data, 8'h00);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);

        wr_en = 1; wr_data = 8'h05; tick(); wr_en = 0;
        chk("R2 no capture without edge", rd_data, 8'h00);

        src_in = 6'h07; tick();
        chk("R3 enabled edges only", rd_data, 8'h05);
        chk("R5 irq high", {7'd0, irq}, 8'h01);

        src_in = 6'h00; tick();
        chk("R9 sticky after fall", rd_data, 8'h05);

        wr_en = 1; wr_data = 8'h01; tick(); wr_en = 0;
        chk("R6 masked bit cleared", rd_data, 8'h01);

        wr_en = 1; wr_data = 8'hFF; tick(); wr_en = 0;
        chk("R4 upper bits zero", rd_data, 8'h01);

        src_in = 6'h02; wr_en = 1; wr_data = 8'h3D; tick(); wr_en = 0;
        chk("R7 clear wins", rd_data, 8'h01);

        wr_en = 1; wr_data = 8'h3F; tick(); wr_en = 0;
        tick();
        chk("R10 held high no recapture", rd_data, 8'h01);

        src_in = 6'h00; tick();
        src_in = 6'h02; tick();
        chk("R10 new edge captured", rd_data, 8'h03);

        wr_en = 1; wr_data = 8'h00; tick(); wr_en = 0;
        chk("R8 write zero clears", rd_data, 8'h00);
        chk("R8 irq low", {7'd0, irq}, 8'h00);

        src_in = 6'h12; wr_en = 1; wr_data = 8'h10; tick(); wr_en = 0;
        chk("R11 edge with enabling write", rd_data, 8'h00);

        src_in = 6'h00; wr_en = 1; wr_data = 8'h3F; tick(); wr_en = 0;
        src_in = 6'h30; tick();
        chk("R3 two sources", rd_data, 8'h30);
        wr_en = 1; wr_data = 8'h0F; tick();
        chk("R6 ack by mask", rd_data, 8'h00);
        chk("R5 irq drops", {7'd0, irq}, 8'h00);
        wr_data = 8'h3F; tick(); wr_en = 0;
        chk("R2 restore mask no recapture", rd_data, 8'h00);

        for (int i = 0; i < 500; i++) begin
            src_in  = 6'($urandom);
            wr_en   = (($urandom % 4) == 0);
            wr_data = 8'($urandom);
            tick();
        end
        wr_en = 0;

        done = 1;
        summary();
        $finish;
    end
endmodule